// File: doc/BRIEF.md
# Paged write cache sequencer

This block gathers a burst of write bytes into a 64-byte cache and then commits it to a memory array one page at a time. A write opens with a start address, continues with any number of data bytes, and closes with a stop event. The cache has 8 pages of 8 bytes. The first byte always goes into cache page 0, at the byte offset given by the low three address bits. Later bytes fill the following cache positions. Bytes past the end of the cache wrap back into page 0 and overwrite what is already there.

After the stop event the block walks the cache from page 0. It issues one timed program operation for each page that holds at least one loaded byte. Each operation presents the array page address, eight data bytes and a per-byte enable mask. Cache page 0 goes to the array page that holds the start address, and each later page goes to the next array page, wrapping at the top of the array. A busy flag covers the whole commit, and every command is ignored while it is high. The array itself sits outside the block.

Top module: `paged_wcache`

## Requirements
- R1: After `wr_start`, the k-th accepted data byte (k = 0, 1, ...) is placed at cache index (`start_addr[2:0]` + k) mod 64, where cache index i is byte i mod 8 of cache page i / 8. A full 64-byte load from an unaligned start therefore fills the leading bytes of cache page 0 last.
- R2: Bytes beyond the 64th wrap to cache index 0 onward and replace the earlier contents. Only the latest value at each index is committed.
- R3: Cache page p is programmed to array page (`start_addr[12:3]` + p) mod 1024. Program operations come in increasing p order, so consecutive operations carry consecutive page numbers, and page 1023 is followed by page 0.
- R4: `prog_be[j]` is 1 exactly when byte j of the page being programmed was loaded since the last `wr_start`. `prog_data[8j+7:8j]` carries that byte. Array bytes whose enable is 0 stay unchanged.
- R5: A stop with at least one loaded byte raises `busy` on the clock edge that samples the stop. Each loaded cache page then gets one single-cycle `prog_valid` pulse followed by PROG_CYCLES cycles of program time, whether the page is full or partial. `busy` stays high for exactly K*(PROG_CYCLES+1) cycles, where K is the number of loaded pages.
- R6: A stop with no bytes loaded issues no program operation and leaves `busy` low. `stop` and `data_valid` while no write is open have no effect.
- R7: While `busy` is high, `wr_start`, `data_valid` and `stop` are ignored. They change neither the committed data nor the length of the commit.
- R8: After reset, `busy` and `prog_valid` are low.
- R9: A `wr_start` during loading restarts the write. The new start address applies, and bytes loaded before the restart are never committed.
- R10: A byte presented together with `stop` is loaded before the commit begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Opens (or restarts) a write at `start_addr` |
| start_addr | input | ADDR_W | Byte start address of the write |
| data_valid | input | 1 | `data_byte` is to be loaded this cycle |
| data_byte | input | 8 | Write data byte |
| stop | input | 1 | Ends loading and starts the commit |
| busy | output | 1 | Commit in progress; commands ignored |
| prog_valid | output | 1 | One-cycle pulse starting a page program |
| prog_page | output | ADDR_W-3 | Array page address of the program |
| prog_data | output | 64 | Eight data bytes, byte j in bits 8j+7..8j |
| prog_be | output | 8 | Per-byte write enables |

## Verification
Assertions check on every cycle that each program pulse carries at least one enabled byte and is never followed directly by another pulse. They also check that pages within one commit come in consecutive order and that a commit only ever begins on the edge after a stop. The bench's scenarios are needed for the rest: the cache placement under offsets, overflow and restarts; the exact data that lands in the array; the total commit length; and the rejection of commands while busy. These only show up by comparing the whole array and the cycle counts against a reference computed from the requirements.

// File: rtl/paged_wcache.sv
module paged_wcache #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 8,
  parameter int PAGES       = 8,
  parameter int PROG_CYCLES = 20
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_start,
  input  logic [ADDR_W-1:0]                     start_addr,
  input  logic                                  data_valid,
  input  logic [7:0]                            data_byte,
  input  logic                                  stop,
  output logic                                  busy,
  output logic                                  prog_valid,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  prog_page,
  output logic [8*PAGE_BYTES-1:0]               prog_data,
  output logic [PAGE_BYTES-1:0]                 prog_be
);

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int DEPTH  = PAGES * PAGE_BYTES;
  localparam int PG_W   = $clog2(PAGES);
  localparam int IDX_W  = PG_W + OFF_W;
  localparam int TMR_W  = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_ISSUE, S_WAIT} state_t;

  state_t             st;
  logic [7:0]         cache [DEPTH];
  logic [DEPTH-1:0]   loaded;
  logic [IDX_W-1:0]   wptr;
  logic [PAGE_W-1:0]  base;
  logic [PG_W-1:0]    pg;
  logic [TMR_W-1:0]   tmr;
  logic               more;

  wire take_start = wr_start && (st == S_IDLE || st == S_LOAD);
  wire take_byte  = data_valid && st == S_LOAD && !wr_start;
  wire take_stop  = stop && st == S_LOAD && !wr_start;

  always_comb begin
    more = 1'b0;
    for (int p = 0; p < PAGES; p++)
      if (PG_W'(p) > pg && |loaded[p*PAGE_BYTES +: PAGE_BYTES]) more = 1'b1;
  end

  always_ff @(posedge clk)
    if (take_byte) cache[wptr] <= data_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      loaded <= '0;
      wptr   <= '0;
      base   <= '0;
      pg     <= '0;
      tmr    <= '0;
    end else begin
      if (take_start) begin
        base   <= start_addr[ADDR_W-1:OFF_W];
        wptr   <= {PG_W'(0), start_addr[OFF_W-1:0]};
        loaded <= '0;
        st     <= S_LOAD;
      end else begin
        if (take_byte) begin
          loaded[wptr] <= 1'b1;
          wptr         <= wptr + 1'b1;
        end
        case (st)
          S_LOAD:
            if (take_stop) begin
              pg <= '0;
              st <= (|loaded || data_valid) ? S_ISSUE : S_IDLE;
            end
          S_ISSUE: begin
            tmr <= TMR_W'(PROG_CYCLES - 1);
            st  <= S_WAIT;
          end
          S_WAIT:
            if (tmr == '0) begin
              if (more) begin
                pg <= pg + 1'b1;
                st <= S_ISSUE;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              tmr <= tmr - 1'b1;
            end
          default: ;
        endcase
      end
    end
  end

  assign busy       = (st == S_ISSUE) || (st == S_WAIT);
  assign prog_valid = (st == S_ISSUE);
  assign prog_page  = base + PAGE_W'(pg);
  assign prog_be    = loaded[{pg, OFF_W'(0)} +: PAGE_BYTES];

  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_rd
    assign prog_data[8*b +: 8] = cache[{pg, OFF_W'(b)}];
  end

  logic              seen;
  logic [PAGE_W-1:0] last_page;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      last_page <= '0;
    end else if (!busy) begin
      seen <= 1'b0;
    end else if (prog_valid) begin
      seen      <= 1'b1;
      last_page <= prog_page;
    end
  end

  AST_PROG_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |-> prog_be != '0); // R4
  AST_PROG_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |=> !prog_valid); // R5
  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop)); // R5
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && seen) |-> prog_page == last_page + 1'b1); // R3

endmodule

// File: tb/paged_wcache_bench.sv
`timescale 1ns/1ps
module paged_wcache_bench;
  localparam int P = 20;

  logic        clk = 0, rst_n = 0;
  logic        wr_start = 0, data_valid = 0, stop = 0;
  logic [12:0] start_addr = '0;
  logic [7:0]  data_byte = '0;
  logic        busy, prog_valid;
  logic [9:0]  prog_page;
  logic [63:0] prog_data;
  logic [7:0]  prog_be;

  always #2.5 clk = ~clk;

  paged_wcache #(.ADDR_W(13), .PAGE_BYTES(8), .PAGES(8), .PROG_CYCLES(P)) u_paged_wcache (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .start_addr(start_addr),
    .data_valid(data_valid), .data_byte(data_byte), .stop(stop), .busy(busy),
    .prog_valid(prog_valid), .prog_page(prog_page), .prog_data(prog_data), .prog_be(prog_be));

  logic [7:0] arr [8192];
  logic [7:0] exp_arr [8192];
  logic [7:0] mc [64];
  bit         mv [64];
  int         mptr;
  logic [9:0] mbase;
  logic [9:0] seq [16];
  int n_chk = 0, n_fail = 0, n_prog = 0;

  always @(negedge clk)
    if (prog_valid) begin
      for (int b = 0; b < 8; b++)
        if (prog_be[b]) arr[{prog_page, 3'(b)}] = prog_data[8*b +: 8];
      if (n_prog < 16) seq[n_prog] = prog_page;
      n_prog++;
    end

  function automatic int busy_len(int k);
    return k * (P + 1);
  endfunction

  function automatic logic [9:0] page_of(logic [9:0] b, int p);
    return 10'((int'(b) + p) % 1024);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic begin_write(logic [12:0] a);
    wr_start = 1; start_addr = a;
    @(negedge clk);
    wr_start = 0;
    mbase = a[12:3]; mptr = int'(a[2:0]);
    for (int i = 0; i < 64; i++) mv[i] = 0;
  endtask

  task automatic put_byte(logic [7:0] d, bit with_stop);
    data_valid = 1; data_byte = d; stop = with_stop;
    @(negedge clk);
    data_valid = 0; stop = 0;
    mc[mptr] = d; mv[mptr] = 1; mptr = (mptr + 1) % 64;
  endtask

  task automatic finish_write(bit junk, bit stop_on_byte, string req);
    int cnt, k, bad, first_bad;
    logic [9:0] epg [8];
    if (!stop_on_byte) begin
      n_prog = 0;
      stop = 1;
      @(negedge clk);
      stop = 0;
    end
    cnt = 0;
    while (busy && cnt < 100000) begin
      cnt++;
      if (junk) begin
        wr_start = 1'($urandom); start_addr = 13'($urandom);
        data_valid = 1'($urandom); data_byte = 8'($urandom); stop = 1'($urandom);
      end
      @(negedge clk);
    end
    wr_start = 0; data_valid = 0; stop = 0;
    k = 0;
    for (int p = 0; p < 8; p++) begin
      bit any = 0;
      for (int b = 0; b < 8; b++) any |= mv[p*8+b];
      if (any) begin
        epg[k] = page_of(mbase, p);
        k++;
        for (int b = 0; b < 8; b++)
          if (mv[p*8+b]) exp_arr[{page_of(mbase, p), 3'(b)}] = mc[p*8+b];
      end
    end
    check(n_prog == k, "R5", "program pulse count", n_prog, k);
    check(cnt == busy_len(k), "R5", "busy cycles", cnt, busy_len(k));
    for (int i = 0; i < k && i < n_prog; i++)
      check(seq[i] == epg[i], "R3", "program page", int'(seq[i]), int'(epg[i]));
    bad = 0; first_bad = 0;
    for (int i = 0; i < 8192; i++)
      if (arr[i] !== exp_arr[i]) begin
        if (bad == 0) first_bad = i;
        bad++;
      end
    check(bad == 0, req, "array content (first bad addr / value)",
          bad == 0 ? 0 : int'(arr[first_bad]), bad == 0 ? 0 : int'(exp_arr[first_bad]));
    if (junk)
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        check(!busy, "R7", "busy after commit with ignored commands", int'(busy), 0);
      end
  endtask

  task automatic run(logic [12:0] a, int len, bit junk, string req);
    begin_write(a);
    for (int i = 0; i < len; i++) put_byte(8'($urandom), 0);
    finish_write(junk, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 8192; i++) begin
      arr[i] = 8'(i * 7 + 3);
      exp_arr[i] = arr[i];
    end
    repeat (3) @(negedge clk);
    check(!busy, "R8", "busy in reset", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !prog_valid, "R8", "outputs after reset", int'({busy, prog_valid}), 0);

    data_valid = 1; stop = 1;
    @(negedge clk);
    data_valid = 0; stop = 0;
    @(negedge clk);
    check(!busy, "R6", "stop while idle", int'(busy), 0);

    run(13'd24, 64, 0, "R1");
    run(13'd26, 64, 0, "R1");
    run(13'd5, 70, 0, "R2");
    run(13'h1FE8, 40, 0, "R3");
    run(13'h0101, 5, 0, "R4");
    run(13'h0040, 0, 0, "R6");

    begin_write(13'h0200);
    for (int i = 0; i < 10; i++) put_byte(8'($urandom), 0);
    begin_write(13'h0305);
    for (int i = 0; i < 3; i++) put_byte(8'($urandom), 0);
    finish_write(0, 0, "R9");

    begin_write(13'h0456);
    put_byte(8'hA1, 0);
    n_prog = 0;
    put_byte(8'hB2, 1);
    finish_write(0, 1, "R10");

    run(13'h0080, 20, 1, "R7");

    for (int t = 0; t < 25; t++)
      run(13'($urandom), int'($urandom_range(0, 80)), 1'($urandom), "R1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule